// File: doc/BRIEF.md
# Register-Mapped SPI Master

This block is the register side of an SPI master. Software reaches it through a 32-bit word port carrying a byte address, a write strobe, a read strobe and byte enables. A transmit FIFO and a receive FIFO, each one byte wide, sit between that port and a serial byte-exchange port. The exchange port is a valid/ready handshake with an external shift engine, which produces the serial clock and returns one received byte for each byte it sends.

Every byte written to the transmit data word goes to the engine unless the control word sets the inhibit bit. If it is set, bytes wait in the transmit FIFO and are sent once the bit is cleared. Each returned byte goes into the receive FIFO. If that FIFO is full, the byte is dropped and an overrun pulse is raised. Four single-cycle event pulses feed a separate interrupt block.

The select word drives the active-low slave-select pins directly. A keyed write to the reset word returns the whole controller to its power-up state.

Top module: `spiRegMaster`

## Requirements
- R1: After reset, status reads 0x00000005, control reads 0, the select word reads 0xFFFFFFFF and every `ssN` pin is high.
- R2: A write or read has effect only when `regByteEn` is 4'hF. Otherwise a write changes nothing, and a read returns 0 and pops nothing.
- R3: Writing exactly 0x0000000A to byte address 0x40 restores the R1 state and empties both FIFOs. Any other value written there is ignored.
- R4: In a control write (address 0x60), bit 5 empties the transmit FIFO and bit 6 empties the receive FIFO in the same cycle. Neither bit is stored, so both read back as 0.
- R5: While control bit 8 is set, `xchgValid` stays low and transmit bytes accumulate. Once it is clear, the queued bytes are sent in order.
- R6: Status (address 0x64) holds bit 3 transmit full, bit 2 transmit empty, bit 1 receive full and bit 0 receive empty. Writes to status are ignored.
- R7: A write to address 0x68 queues bits 7:0 of the data. Each FIFO holds 256 bytes, and a transmit write to a full FIFO is dropped.
- R8: `xchgValid` is high with the oldest queued byte on `xchgTxByte`. One byte moves per cycle in which `xchgValid` and `xchgReady` are both high. While ready is low, the offered byte stays stable.
- R9: A byte returned while the receive FIFO is full (and not being read) is dropped, and `evtRxOverrun` pulses one cycle later. A push that fills the FIFO pulses `evtRxFull` one cycle later.
- R10: A read of address 0x6C with the receive FIFO empty returns 0xDEADBEEF and changes nothing. Otherwise the read returns the oldest byte in bits 7:0 and removes it.
- R11: `ssN[i]` equals bit i of the select word (address 0x70).
- R12: The occupancy words (0x74 transmit, 0x78 receive) read the FIFO count minus one, or 0 when the FIFO is empty.
- R13: One cycle after a byte exchange, `evtRxNotEmpty` pulses if the byte was stored. `evtTxEmpty` pulses if that exchange left the transmit FIFO empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| regWrEn | input | 1 | Register write strobe |
| regRdEn | input | 1 | Register read strobe |
| regAddr | input | 7 | Byte address, word aligned |
| regByteEn | input | 4 | Byte enables; only 4'hF is accepted |
| regWdata | input | 32 | Write data |
| regRdata | output | 32 | Read data, valid in the cycle of regRdEn |
| xchgValid | output | 1 | Byte offered to the shift engine |
| xchgTxByte | output | 8 | Byte to send |
| xchgReady | input | 1 | Shift engine takes the byte |
| xchgRxByte | input | 8 | Byte returned, valid with the handshake |
| ssN | output | NUM_SS | Active-low slave selects |
| evtTxEmpty | output | 1 | Pulse: an exchange emptied the transmit FIFO |
| evtRxNotEmpty | output | 1 | Pulse: a received byte was stored |
| evtRxFull | output | 1 | Pulse: a received byte filled the FIFO |
| evtRxOverrun | output | 1 | Pulse: a received byte was dropped |

## Verification
A wrong FIFO count shows up quickly. It reaches the status bits and the occupancy words on the next read, and `xchgValid` rises or falls in the cycle after the bad update. A wrong head pointer stays hidden until that entry reaches the port: it appears as a wrong `xchgTxByte` on the next exchange, or as a wrong byte on the next receive read. Mistakes at the full boundary, such as a lost overrun or a byte stored into a full FIFO, only appear after 256 bytes have been exchanged. For that reason the bench fills both FIFOs completely and reads the status, the occupancy words and the event pulses at that point.

// File: rtl/spiRegPkg.sv
package spiRegPkg;
  // word indices (byte address >> 2) seen by software
  localparam logic [4:0] W_KEY  = 5'h10;
  localparam logic [4:0] W_CTRL = 5'h18;
  localparam logic [4:0] W_STAT = 5'h19;
  localparam logic [4:0] W_TXD  = 5'h1A;
  localparam logic [4:0] W_RXD  = 5'h1B;
  localparam logic [4:0] W_SEL  = 5'h1C;
  localparam logic [4:0] W_TXOC = 5'h1D;
  localparam logic [4:0] W_RXOC = 5'h1E;
  localparam logic [31:0] RESET_KEY   = 32'h0000_000A;
  localparam logic [31:0] EMPTY_MARK  = 32'hDEAD_BEEF;
  localparam int CTRL_TXCLR = 5;
  localparam int CTRL_RXCLR = 6;
  localparam int CTRL_INHIB = 8;

  typedef struct packed {
    logic       txPush;
    logic       txPop;
    logic       txClr;
    logic       rxPush;
    logic       rxPop;
    logic       rxClr;
    logic [7:0] txData;
  } dpStrobeT;
endpackage

// File: rtl/spiRegFifo.sv
module spiRegFifo #(
  parameter int DEPTH = 256,
  parameter int WIDTH = 8,
  localparam int PTRW = $clog2(DEPTH),
  localparam int CNTW = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             clr,
  input  logic             push,
  input  logic             pop,
  input  logic [WIDTH-1:0] wrData,
  output logic [WIDTH-1:0] head,
  output logic [CNTW-1:0]  count
);
  logic [WIDTH-1:0] mem [DEPTH];
  logic [PTRW-1:0]  wrPtr, rdPtr;
  logic             doPush, doPop;

  assign doPop  = pop && (count != '0);
  assign doPush = push && ((count != CNTW'(DEPTH)) || doPop);
  assign head   = mem[rdPtr];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrPtr <= '0;
      rdPtr <= '0;
      count <= '0;
    end else if (clr) begin
      wrPtr <= '0;
      rdPtr <= '0;
      count <= '0;
    end else begin
      if (doPush) wrPtr <= wrPtr + 1'b1;
      if (doPop)  rdPtr <= rdPtr + 1'b1;
      count <= count + CNTW'(doPush) - CNTW'(doPop);
    end
  end

  always_ff @(posedge clk) begin
    if (doPush && !clr) mem[wrPtr] <= wrData;
  end

  AST_COUNT_BOUND: assert property (@(posedge clk) disable iff (!rstN)
    count <= CNTW'(DEPTH)); // R7
  AST_CLR_EMPTIES: assert property (@(posedge clk) disable iff (!rstN)
    clr |=> count == '0); // R4
endmodule

// File: rtl/spiRegDatapath.sv
module spiRegDatapath
  import spiRegPkg::*;
#(
  parameter int DEPTH = 256,
  localparam int CNTW = $clog2(DEPTH + 1)
) (
  input  logic            clk,
  input  logic            rstN,
  input  dpStrobeT        strb,
  input  logic [7:0]      rxByte,
  output logic [7:0]      txHead,
  output logic [7:0]      rxHead,
  output logic [CNTW-1:0] txCount,
  output logic [CNTW-1:0] rxCount
);
  spiRegFifo #(.DEPTH(DEPTH), .WIDTH(8)) u_txFifo (
    .clk(clk), .rstN(rstN), .clr(strb.txClr), .push(strb.txPush),
    .pop(strb.txPop), .wrData(strb.txData), .head(txHead), .count(txCount));

  spiRegFifo #(.DEPTH(DEPTH), .WIDTH(8)) u_rxFifo (
    .clk(clk), .rstN(rstN), .clr(strb.rxClr), .push(strb.rxPush),
    .pop(strb.rxPop), .wrData(rxByte), .head(rxHead), .count(rxCount));
endmodule

// File: rtl/spiRegCtrl.sv
module spiRegCtrl
  import spiRegPkg::*;
#(
  parameter int DEPTH  = 256,
  parameter int NUM_SS = 1,
  localparam int CNTW = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrEn,
  input  logic              regRdEn,
  input  logic [6:0]        regAddr,
  input  logic [3:0]        regByteEn,
  input  logic [31:0]       regWdata,
  output logic [31:0]       regRdata,
  output logic              xchgValid,
  input  logic              xchgReady,
  input  logic [7:0]        txHead,
  input  logic [7:0]        rxHead,
  input  logic [CNTW-1:0]   txCount,
  input  logic [CNTW-1:0]   rxCount,
  output dpStrobeT          strb,
  output logic [NUM_SS-1:0] ssN,
  output logic              evtTxEmpty,
  output logic              evtRxNotEmpty,
  output logic              evtRxFull,
  output logic              evtRxOverrun
);
  localparam logic [CNTW-1:0] FULLCNT = CNTW'(DEPTH);

  logic [31:0] ctrlReg, selReg;
  logic [4:0]  wIdx;
  logic        wrOk, rdOk, softRst, ctrlWr, fire;
  logic        txEmpty, txFull, rxEmpty, rxFull, overrun, stored;

  assign wIdx    = regAddr[6:2];
  assign wrOk    = regWrEn && (regByteEn == 4'hF);
  assign rdOk    = regRdEn && (regByteEn == 4'hF);
  assign softRst = wrOk && (wIdx == W_KEY) && (regWdata == RESET_KEY);
  assign ctrlWr  = wrOk && (wIdx == W_CTRL);
  assign txEmpty = (txCount == '0);
  assign rxEmpty = (rxCount == '0);
  assign txFull  = (txCount == FULLCNT);
  assign rxFull  = (rxCount == FULLCNT);

  assign xchgValid = !ctrlReg[CTRL_INHIB] && !txEmpty;
  assign fire      = xchgValid && xchgReady;

  always_comb begin
    strb.txData = regWdata[7:0];
    strb.txPush = wrOk && (wIdx == W_TXD);
    strb.txPop  = fire;
    strb.txClr  = softRst || (ctrlWr && regWdata[CTRL_TXCLR]);
    strb.rxPop  = rdOk && (wIdx == W_RXD) && !rxEmpty;
    strb.rxPush = fire;
    strb.rxClr  = softRst || (ctrlWr && regWdata[CTRL_RXCLR]);
  end

  assign overrun = fire && rxFull && !strb.rxPop && !strb.rxClr;
  assign stored  = fire && !overrun && !strb.rxClr;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ctrlReg <= '0;
      selReg  <= '1;
    end else if (softRst) begin
      ctrlReg <= '0;
      selReg  <= '1;
    end else begin
      if (ctrlWr) begin
        ctrlReg <= regWdata;
        ctrlReg[CTRL_TXCLR] <= 1'b0;
        ctrlReg[CTRL_RXCLR] <= 1'b0;
      end
      if (wrOk && (wIdx == W_SEL)) selReg <= regWdata;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      evtTxEmpty    <= 1'b0;
      evtRxNotEmpty <= 1'b0;
      evtRxFull     <= 1'b0;
      evtRxOverrun  <= 1'b0;
    end else begin
      evtTxEmpty    <= fire && !strb.txClr && (txCount == CNTW'(1)) && !strb.txPush;
      evtRxNotEmpty <= stored;
      evtRxFull     <= stored && !strb.rxPop && (rxCount == FULLCNT - 1'b1);
      evtRxOverrun  <= overrun;
    end
  end

  for (genvar i = 0; i < NUM_SS; i++) begin : g_sel
    assign ssN[i] = selReg[i];
  end

  always_comb begin
    regRdata = '0;
    if (rdOk) begin
      case (wIdx)
        W_CTRL: regRdata = ctrlReg;
        W_STAT: regRdata = {28'd0, txFull, txEmpty, rxFull, rxEmpty};
        W_RXD:  regRdata = rxEmpty ? EMPTY_MARK : {24'd0, rxHead};
        W_SEL:  regRdata = selReg;
        W_TXOC: regRdata = txEmpty ? '0 : 32'(txCount - 1'b1);
        W_RXOC: regRdata = rxEmpty ? '0 : 32'(rxCount - 1'b1);
        default: regRdata = '0;
      endcase
    end
  end

  AST_INHIBIT_HOLDS: assert property (@(posedge clk) disable iff (!rstN)
    ctrlReg[CTRL_INHIB] && !strb.txClr |=> txCount >= $past(txCount)); // R5
  AST_OFFER_STABLE: assert property (@(posedge clk) disable iff (!rstN)
    xchgValid && !xchgReady && !strb.txClr && !ctrlWr |=> xchgValid && $stable(txHead)); // R8
  AST_OVERRUN_AT_FULL: assert property (@(posedge clk) disable iff (!rstN)
    evtRxOverrun |-> rxFull); // R9
  AST_EMPTY_READ_CLEAN: assert property (@(posedge clk) disable iff (!rstN)
    rdOk && (wIdx == W_RXD) && rxEmpty && !fire |=> rxCount == '0); // R10
  AST_KEY_RESTORES_SEL: assert property (@(posedge clk) disable iff (!rstN)
    softRst |=> (&ssN) && (ctrlReg == '0)); // R3
  AST_BAD_KEY_IGNORED: assert property (@(posedge clk) disable iff (!rstN)
    wrOk && (wIdx == W_KEY) && (regWdata != RESET_KEY) |=> $stable(ctrlReg) && $stable(selReg)); // R3
endmodule

// File: rtl/spiRegMaster.sv
module spiRegMaster
  import spiRegPkg::*;
#(
  parameter int DEPTH  = 256,
  parameter int NUM_SS = 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrEn,
  input  logic              regRdEn,
  input  logic [6:0]        regAddr,
  input  logic [3:0]        regByteEn,
  input  logic [31:0]       regWdata,
  output logic [31:0]       regRdata,
  output logic              xchgValid,
  output logic [7:0]        xchgTxByte,
  input  logic              xchgReady,
  input  logic [7:0]        xchgRxByte,
  output logic [NUM_SS-1:0] ssN,
  output logic              evtTxEmpty,
  output logic              evtRxNotEmpty,
  output logic              evtRxFull,
  output logic              evtRxOverrun
);
  localparam int CNTW = $clog2(DEPTH + 1);

  dpStrobeT        strb;
  logic [7:0]      rxHead;
  logic [CNTW-1:0] txCount, rxCount;

  spiRegCtrl #(.DEPTH(DEPTH), .NUM_SS(NUM_SS)) u_ctrl (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regRdEn(regRdEn),
    .regAddr(regAddr), .regByteEn(regByteEn), .regWdata(regWdata),
    .regRdata(regRdata), .xchgValid(xchgValid), .xchgReady(xchgReady),
    .txHead(xchgTxByte), .rxHead(rxHead), .txCount(txCount),
    .rxCount(rxCount), .strb(strb), .ssN(ssN), .evtTxEmpty(evtTxEmpty),
    .evtRxNotEmpty(evtRxNotEmpty), .evtRxFull(evtRxFull),
    .evtRxOverrun(evtRxOverrun));

  spiRegDatapath #(.DEPTH(DEPTH)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .rxByte(xchgRxByte),
    .txHead(xchgTxByte), .rxHead(rxHead), .txCount(txCount),
    .rxCount(rxCount));
endmodule

// File: tb/spiRegMaster_tb.sv
`timescale 1ns/1ps
module spiRegMaster_tb;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        regWrEn = 1'b0, regRdEn = 1'b0;
  logic [6:0]  regAddr = '0;
  logic [3:0]  regByteEn = 4'hF;
  logic [31:0] regWdata = '0;
  logic [31:0] regRdata;
  logic        xchgValid, xchgReady = 1'b1;
  logic [7:0]  xchgTxByte, xchgRxByte;
  logic [0:0]  ssN;
  logic        evtTxEmpty, evtRxNotEmpty, evtRxFull, evtRxOverrun;
  int testCnt = 0, failCnt = 0;
  int nTxE = 0, nRxNe = 0, nFull = 0, nOvr = 0, nFire = 0;

  always #2.5 clk = ~clk;
  assign xchgRxByte = ~xchgTxByte;  // shift engine model: returns inverted byte

  spiRegMaster u_dut (.*);

  always @(posedge clk) begin
    if (rstN) begin
      if (evtTxEmpty) nTxE++;
      if (evtRxNotEmpty) nRxNe++;
      if (evtRxFull) nFull++;
      if (evtRxOverrun) nOvr++;
      if (xchgValid && xchgReady) nFire++;
    end
  end

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    testCnt++;
    if (act !== exp) begin
      failCnt++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(logic [6:0] a, logic [31:0] d, logic [3:0] be = 4'hF);
    @(negedge clk);
    regWrEn = 1'b1; regAddr = a; regWdata = d; regByteEn = be;
    @(negedge clk);
    regWrEn = 1'b0; regByteEn = 4'hF;
  endtask

  task automatic rd(logic [6:0] a, output logic [31:0] d, input logic [3:0] be = 4'hF);
    @(negedge clk);
    regRdEn = 1'b1; regAddr = a; regByteEn = be;
    #1 d = regRdata;
    @(negedge clk);
    regRdEn = 1'b0; regByteEn = 4'hF;
  endtask

  task automatic doReset();
    rstN = 1'b0;
    idle(2);
    rstN = 1'b1;
    idle(1);
  endtask

  // {isWrite, byteAddr, data-or-expected}
  localparam int NV = 20;
  localparam logic [39:0] VEC [NV] = '{
    {1'b0, 7'h64, 32'h0000_0005},  // R1 R6 status after reset
    {1'b0, 7'h70, 32'hFFFF_FFFF},  // R1 select word
    {1'b0, 7'h60, 32'h0000_0000},  // R1 control
    {1'b1, 7'h68, 32'h0000_01A5},  // R7 only low byte queued
    {1'b0, 7'h78, 32'h0000_0000},  // R12 one byte -> 0
    {1'b0, 7'h6C, 32'h0000_005A},  // R10 pop returns exchanged byte
    {1'b0, 7'h6C, 32'hDEAD_BEEF},  // R10 empty marker
    {1'b1, 7'h60, 32'h0000_0100},  // R5 inhibit
    {1'b1, 7'h68, 32'h0000_0011},
    {1'b1, 7'h68, 32'h0000_0022},
    {1'b1, 7'h68, 32'h0000_0033},
    {1'b0, 7'h74, 32'h0000_0002},  // R12 three queued
    {1'b0, 7'h64, 32'h0000_0001},  // R5 R6 held, tx not empty
    {1'b1, 7'h60, 32'h0000_0000},  // R5 release
    {1'b0, 7'h78, 32'h0000_0002},  // R5 all drained
    {1'b0, 7'h6C, 32'h0000_00EE},  // R5 order kept
    {1'b0, 7'h6C, 32'h0000_00DD},
    {1'b0, 7'h6C, 32'h0000_00CC},
    {1'b1, 7'h60, 32'h0000_0160},  // R4 clear bits plus inhibit
    {1'b0, 7'h60, 32'h0000_0100}   // R4 clear bits read zero
  };

  initial begin : watchdog
    #1000000;
    failCnt++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("  [TB] %0d tests run, %0d failed", testCnt, failCnt);
    $finish;
  end

  initial begin : main
    logic [31:0] r;
    int b0, b1, b2;
    doReset();
    chk("R1 ssN after reset", 32'(ssN), 32'h1);

    for (int i = 0; i < NV; i++) begin
      if (VEC[i][39]) wr(VEC[i][38:32], VEC[i][31:0]);
      else begin
        rd(VEC[i][38:32], r);
        chk($sformatf("vector %0d (R1-series table)", i), r, VEC[i][31:0]);
      end
      idle(2);
    end

    // R13 event pulses for a single byte
    doReset();
    b0 = nTxE; b1 = nRxNe;
    wr(7'h68, 32'h7);
    idle(3);
    chk("R13 txEmpty pulse", 32'(nTxE - b0), 1);
    chk("R13 rxNotEmpty pulse", 32'(nRxNe - b1), 1);

    // R9 receive overrun after 257 exchanges
    doReset();
    b0 = nFull; b1 = nOvr;
    for (int i = 0; i < 257; i++) wr(7'h68, 32'(i));
    idle(3);
    chk("R9 rxFull pulse count", 32'(nFull - b0), 1);
    chk("R9 overrun pulse count", 32'(nOvr - b1), 1);
    rd(7'h64, r); chk("R9 R6 status full", r, 32'h6);
    rd(7'h78, r); chk("R12 rx occupancy full", r, 32'd255);
    rd(7'h6C, r); chk("R9 oldest byte kept", r, 32'hFF);
    rd(7'h64, r); chk("R10 read clears rx full", r, 32'h4);
    wr(7'h60, 32'h40);
    rd(7'h64, r); chk("R4 rx clear", r, 32'h5);

    // R7 transmit full and drop
    wr(7'h60, 32'h100);
    for (int i = 0; i < 257; i++) wr(7'h68, 32'(i));
    rd(7'h64, r); chk("R7 R6 tx full", r, 32'h9);
    rd(7'h74, r); chk("R7 extra write dropped", r, 32'd255);
    b2 = nFire;
    wr(7'h60, 32'h120);
    rd(7'h64, r); chk("R4 tx clear", r, 32'h5);
    wr(7'h60, 32'h0);
    idle(3);
    chk("R4 nothing left to send", 32'(nFire - b2), 0);

    // R2 partial access, R6 status write ignored
    wr(7'h70, 32'h0, 4'h3);
    rd(7'h70, r); chk("R2 partial write ignored", r, 32'hFFFF_FFFF);
    wr(7'h64, 32'hFF);
    rd(7'h64, r); chk("R6 status write ignored", r, 32'h5);
    wr(7'h68, 32'h44);
    idle(3);
    rd(7'h6C, r, 4'h1); chk("R2 partial read returns 0", r, 32'h0);
    rd(7'h78, r); chk("R2 partial read no pop", r, 32'h0);
    rd(7'h6C, r); chk("R2 byte still there", r, 32'hBB);

    // R11 select pins, R3 keyed reset
    wr(7'h70, 32'h0);
    idle(1);
    chk("R11 ssN follows select", 32'(ssN), 32'h0);
    wr(7'h40, 32'h5);
    rd(7'h70, r); chk("R3 wrong key ignored", r, 32'h0);
    wr(7'h60, 32'h100);
    wr(7'h68, 32'h9);
    wr(7'h40, 32'hA);
    rd(7'h70, r); chk("R3 key restores select", r, 32'hFFFF_FFFF);
    rd(7'h60, r); chk("R3 key clears control", r, 32'h0);
    rd(7'h64, r); chk("R3 key empties FIFOs", r, 32'h5);
    chk("R3 R11 ssN high", 32'(ssN), 32'h1);

    // R8 backpressure
    xchgReady = 1'b0;
    wr(7'h68, 32'h3C);
    idle(1);
    chk("R8 valid offered", 32'(xchgValid), 1);
    chk("R8 byte offered", 32'(xchgTxByte), 32'h3C);
    idle(3);
    chk("R8 byte held", 32'(xchgTxByte), 32'h3C);
    rd(7'h78, r); chk("R8 nothing received yet", r, 32'h0);
    xchgReady = 1'b1;
    idle(2);
    chk("R8 valid drops after exchange", 32'(xchgValid), 0);
    rd(7'h6C, r); chk("R8 exchanged byte", r, 32'hC3);

    $display("  [TB] %0d tests run, %0d failed", testCnt, failCnt);
    $finish;
  end
endmodule